// File: doc/BRIEF.md
# Prime-Field Transform Butterfly

This block performs one butterfly of an integer transform over the prime field whose modulus is p = 2^64 - 2^32 + 1. Each cycle it may take two field elements `a` and `b` together with a twiddle `w`. It returns two values:

- the modular sum of `a` and `b`;
- the modular difference `a - b`, multiplied by `w` and reduced.

All values are 64-bit words. Several instances can sit side by side, one per lane, to reach several butterflies per clock.

The interface is a valid-qualified stream with a fixed latency of three cycles and no back-pressure. The first stage adds and subtracts. The second stage forms the full 128-bit product. The third stage folds the product back into the field using the modulus identities 2^64 ≡ 2^32 - 1 and 2^96 ≡ -1. The sum travels alongside the product, so both results leave under a single output valid. Inputs are expected to be already reduced, below p.

Top module: `ntt_butterfly`

## Requirements
- R1: When `out_valid` is high, `out_sum` equals (a + b) mod p for the operand set that produced it.
- R2: When `out_valid` is high, `out_prod` equals ((a - b) · w) mod p for that operand set, with the difference taken in the field (p is added when a < b).
- R3: Both outputs are canonical: every value shown with `out_valid` high is below p = 0xFFFFFFFF00000001.
- R4: An operand set presented with `in_valid` high on a rising edge produces `out_valid` high three rising edges later. A cycle with `in_valid` low produces a cycle with `out_valid` low three edges later.
- R5: A new operand set is accepted on every cycle. Back-to-back sets each yield exactly one result, in order, with no loss.
- R6: If a = b or w = 0, `out_prod` is 0.
- R7: If w = 1, `out_prod` equals (a - b) mod p.
- R8: While `rst_n` is low at a rising edge, `out_valid` is low after that edge. Sets in flight at reset never emerge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand set present this cycle |
| in_a | input | 64 | First operand, below p |
| in_b | input | 64 | Second operand, below p |
| in_w | input | 64 | Twiddle factor, below p |
| out_valid | output | 1 | Results present this cycle |
| out_sum | output | 64 | (a + b) mod p |
| out_prod | output | 64 | ((a - b) · w) mod p |

## Verification
The block has no state beyond its pipeline registers, so any internal fault shows at the ports within exactly three cycles of the operand set it corrupts.

- A broken carry test, borrow fix-up or fold step in the reduction shows as a wrong or non-canonical result. It surfaces only on operands that reach that path, so the sweeps pair extreme values near 0, 2^32, 2^63 and p with pseudo-random sets.
- A mis-timed sum delay or valid bit shows as results arriving a cycle early or late.
- A mis-timed path can also pair a sum with the wrong product. Streaming distinct sets back-to-back exposes this.

// File: rtl/ntt_butterfly.sv
module ntt_butterfly (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_a,
  input  logic [63:0] in_b,
  input  logic [63:0] in_w,
  output logic        out_valid,
  output logic [63:0] out_sum,
  output logic [63:0] out_prod
);

  localparam logic [63:0] P   = 64'hFFFF_FFFF_0000_0001;
  localparam logic [63:0] EPS = 64'h0000_0000_FFFF_FFFF;

  logic [64:0] add_raw;
  logic [63:0] add_mod, sub_mod;
  assign add_raw = {1'b0, in_a} + {1'b0, in_b};
  assign add_mod = (add_raw[64] || add_raw[63:0] >= P) ? add_raw[63:0] - P : add_raw[63:0];
  assign sub_mod = (in_a < in_b) ? in_a - in_b + P : in_a - in_b;

  logic        v1, v2;
  logic [63:0] sum1, diff1, w1, sum2;
  logic [127:0] prod2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      out_valid <= v2;
    end
  end

  always_ff @(posedge clk) begin
    sum1  <= add_mod;
    diff1 <= sub_mod;
    w1    <= in_w;
    sum2  <= sum1;
    prod2 <= {64'd0, diff1} * {64'd0, w1};
  end

  logic [63:0] lo, t0, t1, folded, reduced;
  logic [31:0] hl, hh;
  logic [64:0] acc;
  assign lo = prod2[63:0];
  assign hl = prod2[95:64];
  assign hh = prod2[127:96];
  assign t0 = (lo < {32'd0, hh}) ? lo - {32'd0, hh} - EPS : lo - {32'd0, hh};
  assign t1 = {hl, 32'd0} - {32'd0, hl};
  assign acc = {1'b0, t0} + {1'b0, t1};
  assign folded  = acc[64] ? acc[63:0] + EPS : acc[63:0];
  assign reduced = (folded >= P) ? folded - P : folded;

  always_ff @(posedge clk) begin
    out_sum  <= sum2;
    out_prod <= reduced;
  end

endmodule

// File: rtl/ntt_butterfly_checker.sv
module ntt_butterfly_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_a,
  input logic [63:0] in_b,
  input logic [63:0] in_w,
  input logic        out_valid,
  input logic [63:0] out_sum,
  input logic [63:0] out_prod
);
  localparam logic [63:0] P = 64'hFFFF_FFFF_0000_0001;

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    since_rst == 2'd3 |-> out_valid == $past(in_valid, 3)); // R4
  AST_SUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sum < P); // R3
  AST_PROD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_prod < P); // R3
  AST_EQUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && out_valid && $past(in_a, 3) == $past(in_b, 3)) |-> out_prod == 64'd0); // R6
  AST_WZERO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && out_valid && $past(in_w, 3) == 64'd0) |-> out_prod == 64'd0); // R6
  AST_WONE_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && out_valid && $past(in_w, 3) == 64'd1 && $past(in_a, 3) >= $past(in_b, 3))
      |-> out_prod == $past(in_a, 3) - $past(in_b, 3)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R8
endmodule

bind ntt_butterfly ntt_butterfly_checker i_checker (.*);

// File: tb/test_ntt_butterfly.sv
`timescale 1ns/1ps
module test_ntt_butterfly;
  localparam logic [63:0] P = 64'hFFFF_FFFF_0000_0001;
  localparam real HALF = 4.0;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [63:0] in_a = '0, in_b = '0, in_w = '0;
  logic out_valid;
  logic [63:0] out_sum, out_prod;

  ntt_butterfly i_ntt_butterfly (.*);

  always #(HALF) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [63:0] q_sum[$], q_prod[$];
  int q_cyc[$], q_tag[$];
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] corner(input int i);
    case (i)
      0: return 64'd0;
      1: return 64'd1;
      2: return 64'd2;
      3: return P - 64'd1;
      4: return P - 64'd2;
      5: return 64'h0000_0000_FFFF_FFFF;
      6: return 64'h0000_0001_0000_0000;
      default: return 64'h8000_0000_0000_0000;
    endcase
  endfunction

  function automatic logic [63:0] next_rand();
    rng ^= rng << 13;
    rng ^= rng >> 7;
    rng ^= rng << 17;
    return (rng >= P) ? rng - P : rng;
  endfunction

  task automatic issue(input bit v, input logic [63:0] a, input logic [63:0] b, input logic [63:0] w);
    logic [127:0] s, d, m;
    @(negedge clk);
    in_valid = v; in_a = a; in_b = b; in_w = w;
    if (v) begin
      s = ({64'd0, a} + {64'd0, b}) % {64'd0, P};
      d = ({64'd0, a} + {64'd0, P} - {64'd0, b}) % {64'd0, P};
      m = (d * {64'd0, w}) % {64'd0, P};
      q_sum.push_back(s[63:0]);
      q_prod.push_back(m[63:0]);
      q_cyc.push_back(cyc);
      q_tag.push_back((a == b || w == 64'd0) ? 6 : (w == 64'd1) ? 7 : 2);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_sum.size() == 0) begin
        check(1'b0, "R4 unexpected output", {63'd0, out_valid}, 64'd0);
      end else begin
        logic [63:0] es, ep;
        int ec, et;
        es = q_sum.pop_front(); ep = q_prod.pop_front();
        ec = q_cyc.pop_front(); et = q_tag.pop_front();
        check(cyc - ec == 3, "R4 latency", 64'(cyc - ec), 64'd3);
        check(out_sum == es, "R1 sum", out_sum, es);
        check(out_sum < P && out_prod < P, "R3 range", out_prod, ep);
        case (et)
          6: check(out_prod == ep, "R6 zero product", out_prod, ep);
          7: check(out_prod == ep, "R7 unit twiddle", out_prod, ep);
          default: check(out_prod == ep, "R2 product", out_prod, ep);
        endcase
      end
    end
  end

  task automatic drain_and_check_empty(input string req);
    repeat (5) issue(1'b0, '0, '0, '0);
    check(q_sum.size() == 0, req, 64'(q_sum.size()), 64'd0);
  endtask

  initial begin
    #(HALF * 2.0 * 200000.0);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 reset state", {63'd0, out_valid}, 64'd0);
    @(negedge clk) rst_n = 1'b1;

    // R5 back-to-back sweep over all corner triples (R1 R2 R3 R6 R7)
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 8; k++)
          issue(1'b1, corner(i), corner(j), corner(k));
    drain_and_check_empty("R5 lost results after corner sweep");

    // R5 pseudo-random stream, mixed with corner operands
    for (int n = 0; n < 2000; n++) begin
      logic [63:0] a, b, w;
      a = next_rand(); b = next_rand(); w = next_rand();
      if (n % 7 == 0) b = a;
      if (n % 11 == 0) w = 64'd1;
      if (n % 13 == 0) a = corner(n % 8);
      issue(1'b1, a, b, w);
    end
    drain_and_check_empty("R5 lost results after random stream");

    // R4 bubbles: irregular valid pattern
    for (int n = 0; n < 300; n++)
      issue((n % 3) != 1 && (n % 5) != 0, next_rand(), next_rand(), next_rand());
    drain_and_check_empty("R4 lost results with bubbles");

    // R8 reset with pipeline full
    for (int n = 0; n < 2; n++) issue(1'b1, next_rand(), next_rand(), next_rand());
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    q_sum.delete(); q_prod.delete(); q_cyc.delete(); q_tag.delete();
    @(negedge clk);
    check(out_valid == 1'b0, "R8 valid cleared", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R8 flushed set emerged", {63'd0, out_valid}, 64'd0);
    end

    // R1 R2 explicit boundary: a = b = p-1
    issue(1'b1, P - 64'd1, P - 64'd1, 64'd5);
    issue(1'b1, 64'd0, P - 64'd1, 64'd1);
    drain_and_check_empty("R5 lost boundary results");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule